// File: doc/BRIEF.md
# Indirect Extended-RAM Access Port

This block lets a byte-wide host register bus reach a large battery-backed RAM that does not fit in the bus's 8-bit address space. The host writes a RAM pointer through two pointer registers, one for the low byte and one for the upper bits. It then moves data through one data-port register. A streaming control bit can be set so that the pointer advances by one after every data-port access. With that bit set, a whole block of RAM can be written or read back with repeated accesses to the same offset.

The pointer registers, the data port and the streaming-control register sit in the upper register window. They only appear there while the bank-select bit is set. While that bit is clear, the same window is an ordinary 64-byte scratch RAM. The RAM depth is a parameter, and a second parameter removes the streaming feature. In that variant the control bit becomes plain storage.

Top module: `xram_port`

## Requirements
- R1: After reset the bank-select register, the streaming-control register and the RAM pointer are all zero, and `bus_rdata` reads 0.
- R2: The bank-select register at offset 0x0A stores the whole written byte and reads it back. Its bit 4 selects bank 1 when 1 and bank 0 when 0.
- R3: In bank 1, offset 0x50 holds the pointer's low 8 bits and offset 0x51 holds the bits above them. Written bits at or above log2(DEPTH) are dropped and read back as 0.
- R4: In bank 1, a write to offset 0x53 stores the byte at the pointer. A read of 0x53 returns the byte at the pointer.
- R5: In bank 1, offset 0x4A is a readable control byte whose bit 5 enables streaming. While that bit is 1, each read or write of 0x53 advances the pointer by one after the access, and a read returns the byte at the old pointer.
- R6: An advance from pointer DEPTH-1 wraps the pointer to 0.
- R7: While the streaming bit is 0, data-port accesses leave the pointer unchanged.
- R8: In bank 0, offsets 0x40 to 0x7F form a 64-byte scratch RAM (byte index = offset minus 0x40). Writes there change neither the pointer nor the extended RAM.
- R9: Read data appears on `bus_rdata` one clock after the read strobe and holds until the next read. Offsets outside 0x0A and 0x40 to 0x7F read 0, as do unused bank-1 offsets in that window.
- R10: With streaming support removed by parameter, bit 5 of offset 0x4A is stored and read back, but data-port accesses never move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe (wins over a read strobe) |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
A streaming fill writes every RAM byte with a distinct pattern and runs the pointer through its wrap point. Later reads therefore tell a wrong increment or a lost write from a correct one. Directed cases set the pointer to the last location, write over-wide upper pointer bits, and turn streaming off. These separate the wrap, the masking and the hold behaviour. Random traffic then mixes bank switches, pointer loads, data-port accesses and scratch-RAM accesses. This shows that the bank gating routes each offset to the right storage. A second instance without streaming support shows that the control bit is kept but has no effect.

// File: rtl/xram_pkg.sv
package xram_pkg;
   localparam logic [7:0] OFS_BANK  = 8'h0A;
   localparam logic [7:0] OFS_STRM  = 8'h4A;
   localparam logic [7:0] OFS_PLO   = 8'h50;
   localparam logic [7:0] OFS_PHI   = 8'h51;
   localparam logic [7:0] OFS_DATA  = 8'h53;
   localparam int         BANK_BIT  = 4;
   localparam int         STRM_BIT  = 5;
   localparam int         SCR_DEPTH = 64;

   typedef enum logic [1:0] {
      SRC_REG  = 2'd0,
      SRC_XRAM = 2'd1,
      SRC_SCR  = 2'd2
   } rd_src_t;

   function automatic logic in_window(input logic [7:0] a);
      return a[7:6] == 2'b01;
   endfunction
endpackage

// File: rtl/xram_array.sv
module xram_array #(
   parameter int DEPTH = 2048,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic          re,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
      if (re) rdata <= mem[addr];
   end
endmodule

// File: rtl/xram_regs.sv
module xram_regs
   import xram_pkg::*;
#(
   parameter int AW       = 11,
   parameter bit BURST_EN = 1'b1,
   localparam int HI_W    = AW - 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_bank,
   input  logic          wr_strm,
   input  logic          wr_lo,
   input  logic          wr_hi,
   input  logic          dp_acc,
   input  logic [7:0]    wdata,
   output logic [7:0]    bank_q,
   output logic [7:0]    strm_q,
   output logic [AW-1:0] ptr_q,
   output logic          step_en
);
   generate
      if (BURST_EN) begin : g_step
         assign step_en = strm_q[STRM_BIT];
      end else begin : g_nostep
         assign step_en = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '0;
         strm_q <= '0;
         ptr_q  <= '0;
      end else begin
         if (wr_bank) bank_q <= wdata;
         if (wr_strm) strm_q <= wdata;
         if (wr_lo)
            ptr_q[7:0] <= wdata;
         else if (wr_hi)
            ptr_q[AW-1:8] <= wdata[HI_W-1:0];
         else if (dp_acc && step_en)
            ptr_q <= ptr_q + AW'(1);
      end
   end

   // R5 R6
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_acc && step_en) |=> (ptr_q == $past(ptr_q) + AW'(1)));

   // R7 R10
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_acc && !step_en) |=> $stable(ptr_q));

   // R2
   bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_bank |=> (bank_q == $past(wdata)));
endmodule

// File: rtl/xram_port.sv
module xram_port
   import xram_pkg::*;
#(
   parameter int DEPTH    = 2048,
   parameter bit BURST_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [7:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata
);
   localparam int AW   = $clog2(DEPTH);
   localparam int HI_W = AW - 8;

   generate
      if (!(DEPTH == 2048 || DEPTH == 4096 || DEPTH == 8192)) begin : g_bad_depth
         $error("xram_port: DEPTH must be 2048, 4096 or 8192");
      end
   endgenerate

   logic [7:0]    bank_q, strm_q;
   logic [AW-1:0] ptr_q;
   logic          step_en;
   logic          rd_eff, bank1, win;
   logic          sel_bank, sel_strm, sel_lo, sel_hi, sel_dp, sel_scr;
   logic [7:0]    xram_dout, scr_dout, reg_val, reg_q;
   rd_src_t       src_q, src_d;

   assign rd_eff   = bus_rd && !bus_wr;
   assign bank1    = bank_q[BANK_BIT];
   assign win      = in_window(bus_addr);
   assign sel_bank = bus_addr == OFS_BANK;
   assign sel_strm = bank1 && bus_addr == OFS_STRM;
   assign sel_lo   = bank1 && bus_addr == OFS_PLO;
   assign sel_hi   = bank1 && bus_addr == OFS_PHI;
   assign sel_dp   = bank1 && bus_addr == OFS_DATA;
   assign sel_scr  = !bank1 && win;

   xram_regs #(.AW(AW), .BURST_EN(BURST_EN)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_bank (bus_wr && sel_bank),
      .wr_strm (bus_wr && sel_strm),
      .wr_lo   (bus_wr && sel_lo),
      .wr_hi   (bus_wr && sel_hi),
      .dp_acc  ((bus_wr || rd_eff) && sel_dp),
      .wdata   (bus_wdata),
      .bank_q  (bank_q),
      .strm_q  (strm_q),
      .ptr_q   (ptr_q),
      .step_en (step_en)
   );

   xram_array #(.DEPTH(DEPTH), .DW(8)) u_xram (
      .clk   (clk),
      .we    (bus_wr && sel_dp),
      .re    (rd_eff && sel_dp),
      .addr  (ptr_q),
      .wdata (bus_wdata),
      .rdata (xram_dout)
   );

   xram_array #(.DEPTH(SCR_DEPTH), .DW(8)) u_scr (
      .clk   (clk),
      .we    (bus_wr && sel_scr),
      .re    (rd_eff && sel_scr),
      .addr  (bus_addr[5:0]),
      .wdata (bus_wdata),
      .rdata (scr_dout)
   );

   always_comb begin
      reg_val = '0;
      src_d   = SRC_REG;
      if (sel_bank)      reg_val = bank_q;
      else if (sel_strm) reg_val = strm_q;
      else if (sel_lo)   reg_val = ptr_q[7:0];
      else if (sel_hi)   reg_val = 8'(ptr_q[AW-1:8]);
      if (sel_dp)        src_d = SRC_XRAM;
      else if (sel_scr)  src_d = SRC_SCR;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= SRC_REG;
         reg_q <= '0;
      end else if (rd_eff) begin
         src_q <= src_d;
         reg_q <= reg_val;
      end
   end

   always_comb begin
      case (src_q)
         SRC_XRAM: bus_rdata = xram_dout;
         SRC_SCR:  bus_rdata = scr_dout;
         default:  bus_rdata = reg_q;
      endcase
   end

   // R9
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_eff |=> $stable(bus_rdata));

   // R3
   hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_eff && sel_hi) |=> (bus_rdata[7:HI_W] == '0));

   // R8
   bank0_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bank1 && win) |=> $stable(ptr_q));

   // R9
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_eff && !win && !sel_bank) |=> (bus_rdata == 8'h00));
endmodule

// File: tb/xram_port_bench.sv
module xram_port_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 2048;
   localparam int AW = $clog2(DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr = 1'b0, rd = 1'b0;
   logic [7:0] addr = '0, wdata = '0;
   logic [7:0] rdata;
   logic n_wr = 1'b0, n_rd = 1'b0;
   logic [7:0] n_addr = '0, n_wdata = '0;
   logic [7:0] n_rdata;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   logic [7:0] m_mem [DEPTH];
   logic [7:0] m_scr [64];
   logic [7:0] m_bank = '0, m_strm = '0;
   logic [AW-1:0] m_ptr = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xram_port #(.DEPTH(DEPTH), .BURST_EN(1'b1)) u_xram_port (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata));

   xram_port #(.DEPTH(DEPTH), .BURST_EN(1'b0)) u_nob (
      .clk(clk), .rst_n(rst_n), .bus_wr(n_wr), .bus_rd(n_rd),
      .bus_addr(n_addr), .bus_wdata(n_wdata), .bus_rdata(n_rdata));

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input logic [7:0] a);
      if (a == 8'h0A) return m_bank;
      if (a[7:6] != 2'b01) return 8'h00;
      if (!m_bank[4]) return m_scr[a[5:0]];
      case (a)
         8'h4A: return m_strm;
         8'h50: return m_ptr[7:0];
         8'h51: return 8'(m_ptr[AW-1:8]);
         8'h53: return m_mem[m_ptr];
         default: return 8'h00;
      endcase
   endfunction

   task automatic mdl(input bit w, input logic [7:0] a, input logic [7:0] d);
      if (w && a == 8'h0A) m_bank = d;
      else if (a[7:6] == 2'b01) begin
         if (!m_bank[4]) begin
            if (w) m_scr[a[5:0]] = d;
         end else if (w && a == 8'h4A) m_strm = d;
         else if (w && a == 8'h50) m_ptr[7:0] = d;
         else if (w && a == 8'h51) m_ptr[AW-1:8] = d[AW-9:0];
         else if (a == 8'h53) begin
            if (w) m_mem[m_ptr] = d;
            if (m_strm[5]) m_ptr = m_ptr + AW'(1);
         end
      end
   endtask

   task automatic bw(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0;
      mdl(1'b1, a, d);
   endtask

   task automatic br(input logic [7:0] a, input string req);
      logic [7:0] e;
      e = exp_rd(a);
      @(negedge clk); rd = 1'b1; addr = a;
      @(negedge clk); rd = 1'b0;
      chk(req, rdata, e);
      mdl(1'b0, a, 8'h00);
   endtask

   task automatic nw(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); n_wr = 1'b1; n_addr = a; n_wdata = d;
      @(negedge clk); n_wr = 1'b0;
   endtask

   task automatic nr(input logic [7:0] a, input logic [7:0] e, input string req);
      @(negedge clk); n_rd = 1'b1; n_addr = a;
      @(negedge clk); n_rd = 1'b0;
      chk(req, n_rdata, e);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] last;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk("R1 rdata reset", rdata, 8'h00);
      rst_n = 1'b1;
      br(8'h0A, "R1 bank reg reset");
      bw(8'h0A, 8'h10);
      br(8'h0A, "R2 bank reg readback");
      br(8'h50, "R1 ptr lo reset");
      br(8'h51, "R1 ptr hi reset");
      br(8'h4A, "R1 stream ctrl reset");
      // R5 streaming fill of the whole RAM, R6 wrap at the end
      bw(8'h4A, 8'h20);
      br(8'h4A, "R5 stream ctrl readback");
      for (int i = 0; i < DEPTH; i++) bw(8'h53, 8'((i * 7 + 3) ^ (i >> 8)));
      br(8'h50, "R6 ptr lo after wrap");
      br(8'h51, "R6 ptr hi after wrap");
      br(8'h53, "R4 R5 read at ptr 0");
      br(8'h50, "R5 ptr advanced after read");
      // R8 scratch RAM in bank 0
      bw(8'h0A, 8'h00);
      for (int i = 0; i < 64; i++) bw(8'(8'h40 + i), 8'(i * 13 + 1));
      br(8'h50, "R8 bank0 offset 0x50 is scratch");
      br(8'h7F, "R8 scratch top byte");
      bw(8'h0A, 8'h10);
      br(8'h50, "R8 ptr untouched by bank0 writes");
      br(8'h53, "R8 xram untouched by bank0 writes");
      // R6 directed wrap from the last location
      bw(8'h50, 8'hFF);
      bw(8'h51, 8'h07);
      br(8'h53, "R6 read last location");
      br(8'h50, "R6 ptr lo wrapped");
      br(8'h51, "R6 ptr hi wrapped");
      // R3 over-wide upper bits dropped
      bw(8'h51, 8'hFF);
      br(8'h51, "R3 upper pointer bits masked");
      bw(8'h50, 8'h3C);
      br(8'h50, "R3 pointer low byte");
      // R7 streaming off
      bw(8'h4A, 8'h00);
      bw(8'h53, 8'hA5);
      br(8'h53, "R7 write then read same address");
      br(8'h53, "R7 repeat read same address");
      br(8'h50, "R7 ptr unchanged");
      // R9 unmapped and hold
      br(8'h20, "R9 unmapped offset");
      br(8'h4B, "R9 unused bank1 offset");
      br(8'h53, "R9 data before hold");
      last = rdata;
      repeat (4) @(negedge clk);
      chk("R9 rdata holds without read", rdata, last);
      // random mix
      for (int k = 0; k < 600; k++) begin
         int op;
         op = int'($urandom % 9);
         case (op)
            0: bw(8'h0A, 8'($urandom) ^ 8'($urandom % 2) << 4);
            1: bw(8'h4A, 8'($urandom));
            2: bw(8'h50, 8'($urandom));
            3: bw(8'h51, 8'($urandom));
            4: bw(8'h53, 8'($urandom));
            5: bw(8'(8'h40 + $urandom % 64), 8'($urandom));
            6: br(8'h53, "R4 R5 random data-port read");
            7: br(8'(8'h40 + $urandom % 64), "R2 R8 random window read");
            default: br(8'($urandom), "R9 random offset read");
         endcase
      end
      // R10 variant without streaming
      nw(8'h0A, 8'h10);
      nw(8'h4A, 8'h20);
      nr(8'h4A, 8'h20, "R10 control bit stored");
      nw(8'h50, 8'h05);
      nw(8'h53, 8'h11);
      nw(8'h53, 8'h22);
      nr(8'h50, 8'h05, "R10 ptr not advanced");
      nr(8'h53, 8'h22, "R10 second write same address");
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule